// File: doc/BRIEF.md
# Byte and Halfword Lane Unit

This datapath unit handles sub-word operands for a 32-bit core that addresses memory by word. A word read from memory is handed to it together with a byte-pointer register. In extract mode it returns the byte or halfword that the pointer's low bits name, zero-extended to a full word. In insert mode it takes three operands: a destination word, a source register and a pointer register. It returns a copy of the destination with the low 8 or 16 bits of the source written into the named lane. The write-back of a partial store then needs only one instruction to form the merged word.

Every operation also drives the lane mask: all-ones over the selected lane, zero elsewhere. Its one's complement is driven as well. Software that builds its own read-modify-write sequence can AND the word with the complement and OR in the aligned value. The unit computes everything combinationally and then passes it through one output register. A valid flag travels with the data, and the outputs hold their last value while no operation is presented.

Top module: `bx_unit`

## Requirements
- R1: Extract with size byte (size_i=0, op_i=0) returns word bits 8k+7..8k in result bits 7..0, where k = sel_i[1:0] (little-endian lanes). Result bits 31..8 are zero.
- R2: Extract with size halfword (size_i=1) returns word bits 16h+15..16h in result bits 15..0, where h = sel_i[1]. sel_i[0] has no effect, and result bits 31..16 are zero.
- R3: An extract with a selector of zero is not a no-op. It truncates the word to its lowest byte or halfword.
- R4: Insert with size byte (op_i=1, size_i=0) writes src_i[7..0] into byte lane sel_i[1:0] of word_i. Every bit of word_i outside that lane is unchanged.
- R5: Insert with size halfword writes src_i[15..0] into halfword lane sel_i[1] of word_i. Every other bit is unchanged, and sel_i[0] has no effect.
- R6: Bits 31..2 of sel_i have no effect on any output.
- R7: For either operation, mask_o has ones exactly over the selected lane (8 bits for a byte, 16 for a halfword), and mask_n_o is its bitwise complement.
- R8: Results appear one clock after the inputs are presented with in_valid high, and out_valid is in_valid delayed by one clock. While in_valid is low, result_o and mask_o keep their previous values.
- R9: While rst_n is low, out_valid, result_o, mask_o and mask_n_o are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operands present this cycle |
| op_i | input | 1 | 0 = extract, 1 = insert |
| size_i | input | 1 | 0 = byte, 1 = halfword |
| word_i | input | 32 | Memory word (extract) or destination word (insert) |
| src_i | input | 32 | Source value; low 8 or 16 bits inserted |
| sel_i | input | 32 | Byte-pointer register; low bits select the lane |
| out_valid | output | 1 | Registered outputs carry a new result |
| result_o | output | 32 | Extracted value or merged word |
| mask_o | output | 32 | Ones over the selected lane |
| mask_n_o | output | 32 | Complement of the lane mask |

## Verification
The assertions take for granted that op_i, size_i and word_i are known (not X) whenever in_valid is high, because they compare registered outputs against the previous cycle's inputs. They also assume that in_valid is low during reset, so that the first post-reset comparison has a defined history. The stimulus drives every input on the falling edge from a reset-quiet state. It keeps in_valid low through reset and changes the data only together with a valid operation or during deliberate idle cycles that test the hold behaviour.

// File: rtl/bx_pkg.sv
package bx_pkg;

    typedef enum logic {
        OP_EXTRACT = 1'b0,
        OP_INSERT  = 1'b1
    } bx_op_e;

    typedef enum logic {
        SZ_BYTE = 1'b0,
        SZ_HALF = 1'b1
    } bx_size_e;

    localparam int unsigned DEF_WORD_W = 32;
    localparam int unsigned DEF_BYTE_W = 8;

endpackage

// File: rtl/bx_lane_decode.sv
module bx_lane_decode #(
    parameter int unsigned NBYTES = 4,
    parameter int unsigned PTR_W  = 2
) (
    input  logic              size_half,
    input  logic [PTR_W-1:0]  ptr,
    output logic [NBYTES-1:0] lane_en
);
    // Byte lane k is active for a byte when ptr == k and for a
    // halfword when it belongs to the pair ptr[PTR_W-1:1].
    for (genvar k = 0; k < NBYTES; k++) begin : g_lane
        assign lane_en[k] = size_half
            ? (ptr[PTR_W-1:1] == (PTR_W-1)'(k / 2))
            : (ptr == PTR_W'(k));
    end

endmodule

// File: rtl/bx_extract.sv
module bx_extract #(
    parameter int unsigned WORD_W = 32,
    parameter int unsigned BYTE_W = 8,
    parameter int unsigned NBYTES = 4,
    parameter int unsigned PTR_W  = 2
) (
    input  logic [WORD_W-1:0] word,
    input  logic              size_half,
    input  logic [PTR_W-1:0]  ptr,
    output logic [WORD_W-1:0] value
);
    localparam int unsigned HALF_W = 2 * BYTE_W;
    localparam int unsigned NHALF  = NBYTES / 2;

    logic [BYTE_W-1:0] byte_lane [NBYTES];
    logic [HALF_W-1:0] half_lane [NHALF];

    for (genvar k = 0; k < NBYTES; k++) begin : g_byte
        assign byte_lane[k] = word[k*BYTE_W +: BYTE_W];
    end

    for (genvar h = 0; h < NHALF; h++) begin : g_half
        assign half_lane[h] = word[h*HALF_W +: HALF_W];
    end

    always_comb begin
        if (size_half) begin
            value = WORD_W'(half_lane[ptr[PTR_W-1:1]]);
        end else begin
            value = WORD_W'(byte_lane[ptr]);
        end
    end

endmodule

// File: rtl/bx_insert.sv
module bx_insert #(
    parameter int unsigned WORD_W = 32,
    parameter int unsigned BYTE_W = 8,
    parameter int unsigned NBYTES = 4
) (
    input  logic [WORD_W-1:0] word,
    input  logic [WORD_W-1:0] src,
    input  logic              size_half,
    input  logic [NBYTES-1:0] lane_en,
    output logic [WORD_W-1:0] merged,
    output logic [WORD_W-1:0] mask
);
    localparam int unsigned HALF_W = 2 * BYTE_W;

    logic unused_src_hi;
    assign unused_src_hi = ^src[WORD_W-1:HALF_W];

    for (genvar k = 0; k < NBYTES; k++) begin : g_lane
        logic [BYTE_W-1:0] ins_byte;
        // A halfword feeds source byte 0 to even lanes and byte 1 to odd ones.
        assign ins_byte = size_half ? src[(k % 2)*BYTE_W +: BYTE_W]
                                    : src[BYTE_W-1:0];
        assign mask[k*BYTE_W +: BYTE_W]   = {BYTE_W{lane_en[k]}};
        assign merged[k*BYTE_W +: BYTE_W] = lane_en[k] ? ins_byte
                                                       : word[k*BYTE_W +: BYTE_W];
    end

endmodule

// File: rtl/bx_unit.sv
module bx_unit
    import bx_pkg::*;
#(
    parameter int unsigned WORD_W = DEF_WORD_W,
    parameter int unsigned BYTE_W = DEF_BYTE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic              op_i,
    input  logic              size_i,
    input  logic [WORD_W-1:0] word_i,
    input  logic [WORD_W-1:0] src_i,
    input  logic [WORD_W-1:0] sel_i,
    output logic              out_valid,
    output logic [WORD_W-1:0] result_o,
    output logic [WORD_W-1:0] mask_o,
    output logic [WORD_W-1:0] mask_n_o
);
    localparam int unsigned NBYTES = WORD_W / BYTE_W;
    localparam int unsigned PTR_W  = $clog2(NBYTES);

    logic [PTR_W-1:0]  ptr;
    logic              is_half;
    logic              is_insert;
    logic [NBYTES-1:0] lane_en;
    logic [WORD_W-1:0] ext_val;
    logic [WORD_W-1:0] ins_val;
    logic [WORD_W-1:0] lane_mask;
    logic [WORD_W-1:0] next_result;
    logic              unused_sel_hi;

    assign ptr           = sel_i[PTR_W-1:0];
    assign unused_sel_hi = ^sel_i[WORD_W-1:PTR_W];
    assign is_half       = (bx_size_e'(size_i) == SZ_HALF);
    assign is_insert     = (bx_op_e'(op_i) == OP_INSERT);

    bx_lane_decode #(
        .NBYTES (NBYTES),
        .PTR_W  (PTR_W)
    ) u_decode (
        .size_half (is_half),
        .ptr       (ptr),
        .lane_en   (lane_en)
    );

    bx_extract #(
        .WORD_W (WORD_W),
        .BYTE_W (BYTE_W),
        .NBYTES (NBYTES),
        .PTR_W  (PTR_W)
    ) u_extract (
        .word      (word_i),
        .size_half (is_half),
        .ptr       (ptr),
        .value     (ext_val)
    );

    bx_insert #(
        .WORD_W (WORD_W),
        .BYTE_W (BYTE_W),
        .NBYTES (NBYTES)
    ) u_insert (
        .word      (word_i),
        .src       (src_i),
        .size_half (is_half),
        .lane_en   (lane_en),
        .merged    (ins_val),
        .mask      (lane_mask)
    );

    assign next_result = is_insert ? ins_val : ext_val;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            result_o  <= '0;
            mask_o    <= '0;
            mask_n_o  <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                result_o <= next_result;
                mask_o   <= lane_mask;
                mask_n_o <= ~lane_mask;
            end
        end
    end

endmodule

// File: rtl/bx_unit_chk.sv
module bx_unit_chk #(
    parameter int unsigned WORD_W = 32,
    parameter int unsigned BYTE_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic              op_i,
    input logic              size_i,
    input logic [WORD_W-1:0] word_i,
    input logic              out_valid,
    input logic [WORD_W-1:0] result_o,
    input logic [WORD_W-1:0] mask_o,
    input logic [WORD_W-1:0] mask_n_o
);
    localparam int unsigned HALF_W = 2 * BYTE_W;

    logic armed;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) armed <= 1'b0;
        else        armed <= 1'b1;
    end

    // R8: valid flag is the input valid one cycle later
    a_r8_valid_delay: assert property (@(posedge clk) disable iff (!rst_n || !armed)
        out_valid == $past(in_valid));

    // R8: idle cycles leave the outputs untouched
    a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n || !armed)
        !$past(in_valid) |-> ($stable(result_o) && $stable(mask_o)));

    // R7: mask width matches the operand size
    a_r7_mask_width: assert property (@(posedge clk) disable iff (!rst_n || !armed)
        out_valid |-> ($countones(mask_o) == ($past(size_i) ? HALF_W : BYTE_W)));

    // R7: the two mask outputs partition the word
    a_r7_mask_pair: assert property (@(posedge clk) disable iff (!rst_n || !armed)
        out_valid |-> (((mask_o & mask_n_o) == '0) && ((mask_o | mask_n_o) == '1)));

    // R4, R5: insert keeps every bit outside the lane
    a_r4_keep_outside: assert property (@(posedge clk) disable iff (!rst_n || !armed)
        (out_valid && $past(op_i)) |-> (((result_o ^ $past(word_i)) & mask_n_o) == '0));

    // R1, R2: extract is zero-extended above the operand size
    a_r1_zero_extend: assert property (@(posedge clk) disable iff (!rst_n || !armed)
        (out_valid && !$past(op_i)) |->
            ((result_o >> ($past(size_i) ? HALF_W : BYTE_W)) == '0));

endmodule

bind bx_unit bx_unit_chk #(
    .WORD_W (WORD_W),
    .BYTE_W (BYTE_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .op_i      (op_i),
    .size_i    (size_i),
    .word_i    (word_i),
    .out_valid (out_valid),
    .result_o  (result_o),
    .mask_o    (mask_o),
    .mask_n_o  (mask_n_o)
);

// File: tb/bx_unit_test.sv
`timescale 1ns/1ps
module bx_unit_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        op_i = 1'b0;
    logic        size_i = 1'b0;
    logic [31:0] word_i = '0;
    logic [31:0] src_i = '0;
    logic [31:0] sel_i = '0;
    logic        out_valid;
    logic [31:0] result_o;
    logic [31:0] mask_o;
    logic [31:0] mask_n_o;

    always #2 clk = ~clk;

    bx_unit uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .op_i      (op_i),
        .size_i    (size_i),
        .word_i    (word_i),
        .src_i     (src_i),
        .sel_i     (sel_i),
        .out_valid (out_valid),
        .result_o  (result_o),
        .mask_o    (mask_o),
        .mask_n_o  (mask_n_o)
    );

    typedef struct {
        logic [31:0] res;
        logic [31:0] mask;
        string       tag;
    } exp_t;

    exp_t queue_q[$];
    exp_t last_exp;
    int   n_tests = 0;
    int   n_fail  = 0;
    bit   finished = 1'b0;

    function automatic exp_t model(input logic op, input logic sz,
                                   input logic [31:0] w, input logic [31:0] s,
                                   input logic [31:0] p, input string tag);
        exp_t e;
        int unsigned sh;
        logic [31:0] fm;
        sh = sz ? 16 * int'(p[1]) : 8 * int'(p[1:0]);
        fm = sz ? 32'h0000_FFFF : 32'h0000_00FF;
        e.mask = fm << sh;
        e.res  = op ? ((w & ~e.mask) | ((s & fm) << sh)) : ((w >> sh) & fm);
        e.tag  = tag;
        return e;
    endfunction

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_tests++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic drive(input logic op, input logic sz, input logic [31:0] w,
                         input logic [31:0] s, input logic [31:0] p, input string tag);
        @(negedge clk);
        in_valid = 1'b1;
        op_i = op; size_i = sz; word_i = w; src_i = s; sel_i = p;
        last_exp = model(op, sz, w, s, p, tag);
        queue_q.push_back(last_exp);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 1'b0;
            word_i = 32'h5A5A_5A5A ^ 32'(i); src_i = ~word_i; sel_i = 32'(i + 1);
            op_i = ~op_i; size_i = ~size_i;
        end
    endtask

    // Monitor: pops expectations as results emerge
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && out_valid) begin
                if (queue_q.size() == 0) begin
                    n_tests++; n_fail++;
                    $display("FAIL R8: unexpected out_valid, got 1 expected 0");
                end else begin
                    exp_t e;
                    e = queue_q.pop_front();
                    check({e.tag, " result"}, result_o, e.res);
                    check({"R7 mask ", e.tag}, mask_o, e.mask);
                    check({"R7 mask_n ", e.tag}, mask_n_o, ~e.mask);
                end
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_tests++; n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] w, s, p;
        repeat (3) @(negedge clk);
        // R9: reset state
        check("R9 out_valid", {31'b0, out_valid}, 32'h0);
        check("R9 result", result_o, 32'h0);
        check("R9 mask", mask_o, 32'h0);
        check("R9 mask_n", mask_n_o, 32'h0);
        @(negedge clk);
        rst_n = 1'b1;
        idle(2);

        // R1: byte extract from each lane
        for (int k = 0; k < 4; k++) drive(1'b0, 1'b0, 32'hA1B2_C3D4, '0, 32'(k), "R1 byte extract");
        // R2: halfword extract, bit 0 ignored
        drive(1'b0, 1'b1, 32'hA1B2_C3D4, '0, 32'd2, "R2 half extract lane1");
        drive(1'b0, 1'b1, 32'hA1B2_C3D4, '0, 32'd3, "R2 half extract bit0 ignored");
        drive(1'b0, 1'b1, 32'hA1B2_C3D4, '0, 32'd1, "R2 half extract lane0");
        // R3: selector zero truncates
        drive(1'b0, 1'b0, 32'hFFFF_8081, '0, 32'd0, "R3 truncate byte");
        drive(1'b0, 1'b1, 32'hFFFF_8081, '0, 32'd0, "R3 truncate half");
        // R6: upper selector bits ignored
        drive(1'b0, 1'b0, 32'hA1B2_C3D4, '0, 32'hFFFF_FFF5, "R6 upper sel bits");
        drive(1'b1, 1'b0, 32'h1122_3344, 32'hDEAD_BEEF, 32'h1234_5672, "R6 upper sel insert");
        // R4: byte insert into each lane
        for (int k = 0; k < 4; k++) drive(1'b1, 1'b0, 32'h1122_3344, 32'hDEAD_BEEF, 32'(k), "R4 byte insert");
        // R5: halfword insert
        drive(1'b1, 1'b1, 32'h1122_3344, 32'hDEAD_BEEF, 32'd3, "R5 half insert lane1");
        drive(1'b1, 1'b1, 32'h1122_3344, 32'hDEAD_BEEF, 32'd1, "R5 half insert lane0");
        drive(1'b1, 1'b1, 32'hFFFF_FFFF, 32'h0000_0000, 32'd2, "R5 half insert zeros");

        // R8: hold while idle
        idle(3);
        check("R8 hold result", result_o, last_exp.res);
        check("R8 hold mask", mask_o, last_exp.mask);
        check("R8 idle out_valid", {31'b0, out_valid}, 32'h0);

        // R1 R2 R4 R5 R7: mixed stream with gaps
        w = 32'h1357_9BDF; s = 32'h2468_ACE0; p = 32'h0F0F_0F0F;
        for (int i = 0; i < 40; i++) begin
            w = {w[30:0], w[31] ^ w[21] ^ w[1] ^ w[0]};
            s = s * 32'd1103515245 + 32'd12345;
            p = p + 32'h0101_0107;
            drive(s[9], s[13], w, s, p, "R4 R1 mixed stream");
            if (i % 7 == 3) idle(1);
        end
        idle(3);
        check("R8 queue drained", 32'(queue_q.size()), 32'h0);

        finished = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule